// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a one-bit sample stream by a whole number of clock cycles. A control word selects the number of cycles. The path is a cascade of bypassable stages whose lengths fall by powers of two, largest first. Each bit of the control word inserts its own stage or routes around it. One stage of fixed length follows the cascade and is always in the path, so the shortest possible delay is never zero.

The control word does not feed the cascade directly. It passes through a control register that can run transparent or hold its last value. Two overrides sit in front of that register. The minimum override wins over everything else and also clears the stored word. The maximum override sets every stage in the path and leaves the stored word untouched. An active-low output enable forces the output low whenever it is deasserted.

The sample stream has no back-pressure and no valid qualifier. One sample goes in and one comes out on every clock. When every control pin is low, the block runs transparent, with no override and the output enabled.

Top module: `pdl_delay_line`

## Requirements
- R1: With the effective word W held steady, sample_out after clock edge k equals the sample_in value sampled at edge k − (W + FIXED_LEN) + 1. The default FIXED_LEN is 2.
- R2: An effective word of zero gives a delay of exactly FIXED_LEN cycles, which is never zero.
- R3: An effective word of all ones (1023 with the default 10-bit width) gives a delay of 1023 + FIXED_LEN cycles.
- R4: While code_hold is low, the effective word follows code_in in the same cycle, and the stored word takes code_in at each edge.
- R5: While code_hold is high, the stored word keeps its value and changes on code_in have no effect on the delay.
- R6: While force_min is high, the effective word is zero whatever force_max, code_hold and code_in are, and the stored word is cleared at each edge. After force_min is released with code_hold high, the delay stays at its minimum.
- R7: While force_max is high and force_min is low, the effective word is all ones. The stored word is not altered, so the earlier delay returns when force_max is released.
- R8: While out_en_n is high, sample_out is 0. While it is low, sample_out carries the delayed stream.
- R9: A synchronous reset clears every delay stage and the stored word to zero.
- R10: After the effective word changes to W, the output matches the R1 relation once more than W + FIXED_LEN edges have passed with W in place. Before that point, stale stage contents may appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 1 | Input sample stream, one bit per cycle |
| code_in | input | CODE_W | Requested delay code |
| code_hold | input | 1 | Low: register transparent. High: register holds |
| force_min | input | 1 | Forces the minimum delay and clears the stored word |
| force_max | input | 1 | Forces the maximum delay when force_min is low |
| out_en_n | input | 1 | Active-low output enable |
| sample_out | output | 1 | Delayed sample stream |

## Verification
The assertions assume that every control input is a clean level sampled at the clock edge. They also assume that reset is held high from time zero until at least one edge has passed. The bench changes controls and sample_in only on the falling edge, and it holds reset for several cycles before releasing it. The output comparison against the stream model is gated. It starts only after the effective word has stayed constant for more than its own delay, which keeps it out of the window of stale samples that the design is allowed to produce. The enable check applies at all times.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  // Source chosen for the effective control word, in priority order.
  typedef enum logic [1:0] {
    SRC_INPUT = 2'd0,
    SRC_HELD  = 2'd1,
    SRC_MAX   = 2'd2,
    SRC_MIN   = 2'd3
  } word_src_e;

  // Length of cascade stage idx; stage 0 carries the heaviest weight.
  function automatic int stage_len(input int idx, input int code_w);
    return 1 << (code_w - 1 - idx);
  endfunction

endpackage

// File: rtl/pdl_ctrl.sv
module pdl_ctrl #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_hold,
  input  logic              force_min,
  input  logic              force_max,
  output logic [CODE_W-1:0] word,
  output logic [CODE_W-1:0] stored
);
  import pdl_pkg::*;

  word_src_e src;

  always_comb begin
    if (force_min)      src = SRC_MIN;
    else if (force_max) src = SRC_MAX;
    else if (code_hold) src = SRC_HELD;
    else                src = SRC_INPUT;
  end

  always_ff @(posedge clk) begin
    if (rst || force_min) stored <= '0;
    else if (!code_hold)  stored <= code_in;
  end

  always_comb begin
    unique case (src)
      SRC_MIN:  word = '0;
      SRC_MAX:  word = '1;
      SRC_HELD: word = stored;
      default:  word = code_in;
    endcase
  end

endmodule

// File: rtl/pdl_stage.sv
module pdl_stage #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic insert,
  output logic dout
);
  logic [LEN-1:0] sr;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LEN-2:0], din};
      end
    end
  endgenerate

  assign dout = insert ? sr[LEN-1] : din;

endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line #(
  parameter int CODE_W    = 10,
  parameter int FIXED_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_hold,
  input  logic              force_min,
  input  logic              force_max,
  input  logic              out_en_n,
  output logic              sample_out
);
  logic [CODE_W-1:0] ctrl_word;
  logic [CODE_W-1:0] ctrl_store;
  logic [CODE_W:0]   tap;
  logic              fixed_out;

  pdl_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_in),
    .code_hold (code_hold),
    .force_min (force_min),
    .force_max (force_max),
    .word      (ctrl_word),
    .stored    (ctrl_store)
  );

  assign tap[0] = sample_in;

  // Heaviest stage first; stage i is selected by word bit CODE_W-1-i.
  generate
    for (genvar i = 0; i < CODE_W; i++) begin : g_cascade
      localparam int LEN = pdl_pkg::stage_len(i, CODE_W);
      pdl_stage #(.LEN(LEN)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .din    (tap[i]),
        .insert (ctrl_word[CODE_W-1-i]),
        .dout   (tap[i+1])
      );
    end
  endgenerate

  pdl_stage #(.LEN(FIXED_LEN)) u_fixed (
    .clk    (clk),
    .rst    (rst),
    .din    (tap[CODE_W]),
    .insert (1'b1),
    .dout   (fixed_out)
  );

  assign sample_out = out_en_n ? 1'b0 : fixed_out;

endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_in,
  input logic              code_hold,
  input logic              force_min,
  input logic              force_max,
  input logic              out_en_n,
  input logic              sample_out,
  input logic [CODE_W-1:0] word,
  input logic [CODE_W-1:0] stored
);

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> stored == '0);

  // R6
  min_clear_chk: assert property (@(posedge clk) disable iff (rst)
    force_min |=> stored == '0);

  // R6
  min_word_chk: assert property (@(posedge clk) disable iff (rst)
    force_min |-> word == '0);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    code_hold && !force_min |=> stored == $past(stored));

  // R4
  track_load_chk: assert property (@(posedge clk) disable iff (rst)
    !code_hold && !force_min |=> stored == $past(code_in));

  // R7
  max_word_chk: assert property (@(posedge clk) disable iff (rst)
    force_max && !force_min |-> word == '1);

  // R8
  out_off_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n && $past(out_en_n) |-> !sample_out);

endmodule

bind pdl_delay_line pdl_delay_line_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .code_in    (code_in),
  .code_hold  (code_hold),
  .force_min  (force_min),
  .force_max  (force_max),
  .out_en_n   (out_en_n),
  .sample_out (sample_out),
  .word       (ctrl_word),
  .stored     (ctrl_store)
);

// File: tb/pdl_delay_line_tb.sv
module pdl_delay_line_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 10;
  localparam int FIXED_LEN  = 2;
  localparam int HIST       = 4096;
  localparam int MAXC       = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_in = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic code_hold = 1'b0;
  logic force_min = 1'b0;
  logic force_max = 1'b0;
  logic out_en_n  = 1'b0;
  logic sample_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdl_delay_line #(.CODE_W(CODE_W), .FIXED_LEN(FIXED_LEN)) u_dut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .code_in(code_in),
    .code_hold(code_hold), .force_min(force_min), .force_max(force_max),
    .out_en_n(out_en_n), .sample_out(sample_out)
  );

  // Behavioural reference state.
  bit hist [HIST];
  int k        = HIST;
  int settle   = 0;
  int reg_m    = 0;
  int prev_eff = 0;

  function automatic int eff_f();
    if (force_min)      return 0;
    else if (force_max) return MAXC;
    else if (code_hold) return reg_m;
    else                return int'(code_in);
  endfunction

  always @(posedge clk) begin
    int e;
    e = eff_f();
    k++;
    if (rst) begin
      settle = 0;
      reg_m  = 0;
      hist[k % HIST] = 1'b0;
    end else begin
      if (e != prev_eff) settle = 0;
      settle++;
      if (force_min)       reg_m = 0;
      else if (!code_hold) reg_m = int'(code_in);
      hist[k % HIST] = sample_in;
    end
    prev_eff = e;
  end

  task automatic report(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sample_out=%b expected %b at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check(string tag);
    int d;
    if (rst) return;
    if (out_en_n) begin
      report(tag, sample_out, 1'b0);
      return;
    end
    d = eff_f() + FIXED_LEN;
    if (settle > d) report(tag, sample_out, hist[(k - d + 1) % HIST]);
  endtask

  task automatic run(string tag, int n);
    repeat (n) begin
      @(negedge clk);
      check(tag);
      sample_in = 1'($urandom % 2);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    finish_up();
  end

  initial begin
    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      sample_in = 1'($urandom % 2);
    end
    report("R9 reset clears stages", sample_out, 1'b0);
    rst = 1'b0;
    run("R9 after reset", 20);

    // R2: zero code gives only the fixed delay
    code_in = '0;
    run("R2 zero code", 60);

    // R1: random codes, transparent load
    for (int i = 0; i < 4; i++) begin
      int c;
      c = int'($urandom % (MAXC + 1));
      code_in = CODE_W'(c);
      run("R1 random code", c + FIXED_LEN + 60);
    end

    // R3: full-scale code
    code_in = '1;
    run("R3 max code", MAXC + FIXED_LEN + 60);

    // R4 and R10: transparent register follows each new code
    code_in = CODE_W'(5);
    run("R4 follow code 5", 80);
    code_in = CODE_W'(77);
    run("R10 resettle code 77", 150);
    code_in = CODE_W'(120);
    run("R4 follow code 120", 200);

    // R5: hold keeps the earlier word, code_in ignored
    code_in = CODE_W'(37);
    run("R5 load 37", 80);
    code_hold = 1'b1;
    code_in = CODE_W'(900);
    run("R5 hold ignores code_in", 150);

    // R6: minimum wins over maximum and clears the register
    code_hold = 1'b0;
    code_in = CODE_W'(500);
    force_min = 1'b1;
    force_max = 1'b1;
    run("R6 force min priority", 60);
    force_max = 1'b0;
    code_hold = 1'b1;
    run("R6 min with hold", 10);
    force_min = 1'b0;
    run("R6 cleared register held", 80);

    // R7: maximum override leaves the stored word intact
    code_hold = 1'b0;
    code_in = CODE_W'(200);
    run("R7 load 200", 260);
    code_hold = 1'b1;
    force_max = 1'b1;
    run("R7 force max", MAXC + FIXED_LEN + 60);
    force_max = 1'b0;
    run("R7 stored word returns", 260);

    // R8: output enable
    code_hold = 1'b0;
    code_in = CODE_W'(3);
    out_en_n = 1'b1;
    run("R8 output disabled", 50);
    out_en_n = 1'b0;
    run("R8 output enabled", 50);

    finish_up();
  end

endmodule